// File: doc/BRIEF.md
# Three-Channel Single-Transfer DMA Engine

This block moves data between memory and peripheral registers on behalf of on-chip peripherals. It has three channels. Each channel holds a fixed peripheral register address, a memory address that advances, a transfer count and a small control word. Every pulse on a channel's request line produces exactly one transfer. A transfer is a bus read from the source into an internal holding register, followed by a bus write of that value to the destination. The channel then waits for its next request.

When more than one channel has a request waiting, the lowest-numbered channel is served first. The winner is picked only between transfers, so a transfer that has started always finishes on the same channel. Software loads the count with N−1 to get N transfers, which allows up to 256 transfers per run. The last transfer sets the channel's done flag and clears its enable. The channel's interrupt line follows the done flag until software clears the flag.

The bus port has one master. The engine raises a bus request and waits for a grant before its first access. It keeps the request high until the write of the transfer is accepted.

Top module: `dma3_engine`

## Requirements
- R1: The peripheral address register (register select 0) stores only bits 9:1 of the written value. Bits 15:10 and bit 0 always read as zero.
- R2: When several enabled channels have requests waiting at the same time, they are served in ascending channel order: 0, then 1, then 2.
- R3: One request pulse on an enabled channel produces exactly one transfer, which is one read and one write. After the accepted write, the engine drops the bus valid signal and the channel waits for its next request.
- R4: A transfer reads the source and then writes the value it read to the destination. Control bit 2 set means memory to peripheral. Control bit 2 clear means peripheral to memory.
- R5: Control bit 1 selects 16-bit units when set and 8-bit units when clear. An 8-bit transfer writes the low byte of the read data, with bits 15:8 of the write data at zero.
- R6: After each transfer the memory address (register select 1) grows by 2 for 16-bit units and by 1 for 8-bit units. The peripheral address never changes.
- R7: The count register (register select 2, 8 bits) is decremented after each transfer. When a transfer completes with the count at 0, the engine sets the done flag (control bit 3) and clears the enable (control bit 0). A count of 0xFF gives 256 transfers.
- R8: A channel's interrupt output is high exactly while its done flag is set. Software clears the flag by writing 0 to control bit 3 (register select 3).
- R9: The engine holds bus valid low until it has seen bus grant. Bus request stays high from the grant wait until the accepted write.
- R10: A request that arrives during another channel's transfer is kept waiting. The next winner is chosen after the current transfer completes, by the order of R2.
- R11: A request pulse on a disabled channel is dropped. Enabling the channel later does not start a transfer for that pulse.
- R12: After reset, all enables, done flags and interrupts are zero, and bus request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Channel select for register access |
| cfgReg | input | 2 | Register select: 0 peripheral address, 1 memory address, 2 count, 3 control |
| cfgWdata | input | 16 | Register write data |
| cfgRdata | output | 16 | Register read data (combinational) |
| dmaReq | input | 3 | Per-channel request pulses |
| busReq | output | 1 | Bus ownership request |
| busGnt | input | 1 | Bus ownership grant |
| busValid | output | 1 | Bus access valid |
| busWe | output | 1 | 1 = write access, 0 = read access |
| busWide | output | 1 | 1 = 16-bit access, 0 = 8-bit access |
| busAddr | output | 16 | Bus access address |
| busWdata | output | 16 | Bus write data |
| busRdata | input | 16 | Bus read data, sampled when busRdy is high |
| busRdy | input | 1 | Access accepted this cycle |
| irq | output | 3 | Per-channel completion interrupt |

## Verification
The hardest case to reach is a higher-priority request that arrives while a lower channel's transfer is already on the bus. That request must wait and must then beat a channel that asked earlier. The stimulus pulses channel 2 and watches the ports for its first valid access. It then pulses channel 1 and, one cycle later, channel 0, so both land inside the running transfer. The scoreboard expects the order 2, 0, 1. The 256-transfer boundary gets a full run with a count of 0xFF, and the done flag is checked after the 255th and after the 256th transfer.

// File: rtl/dma3_pkg.sv
package dma3_pkg;

  localparam int DATA_W   = 16;
  localparam int CH_IDX_W = 2;

  localparam int CB_EN    = 0;
  localparam int CB_WIDE  = 1;
  localparam int CB_TOPER = 2;
  localparam int CB_TC    = 3;

  typedef enum logic [1:0] {
    REG_PERIPH = 2'd0,
    REG_MEM    = 2'd1,
    REG_COUNT  = 2'd2,
    REG_CTRL   = 2'd3
  } cfgReg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } xferState_t;

  typedef struct packed {
    logic                grant;
    logic [CH_IDX_W-1:0] ch;
    logic                capture;
    logic                finish;
    logic                phaseWr;
  } dmaCmd_t;

endpackage

// File: rtl/dma3_ctrl.sv
module dma3_ctrl
  import dma3_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] enMask,
  input  logic              busGnt,
  input  logic              busRdy,
  output logic              busReq,
  output logic              busValid,
  output logic              busWe,
  output dmaCmd_t           cmd
);

  xferState_t state, stateNxt;
  logic [NUM_CH-1:0]   pending;
  logic [NUM_CH-1:0]   ready;
  logic [NUM_CH-1:0]   grantMask;
  logic [CH_IDX_W-1:0] pickCh;
  logic                anyReady;

  assign ready = pending & enMask;

  // Fixed priority: lowest index wins, written last.
  always_comb begin
    pickCh   = '0;
    anyReady = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ready[i]) begin
        pickCh   = CH_IDX_W'(i);
        anyReady = 1'b1;
      end
    end
  end

  always_comb begin
    cmd.grant   = (state == ST_IDLE) && anyReady;
    cmd.ch      = pickCh;
    cmd.capture = (state == ST_RD) && busRdy;
    cmd.finish  = (state == ST_WR) && busRdy;
    cmd.phaseWr = (state == ST_WR);
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_gmask
      assign grantMask[g] = cmd.grant && (pickCh == CH_IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= ((pending & ~grantMask) | req) & enMask;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: if (anyReady) stateNxt = ST_HOLD;
      ST_HOLD: if (busGnt)   stateNxt = ST_RD;
      ST_RD:   if (busRdy)   stateNxt = ST_WR;
      ST_WR:   if (busRdy)   stateNxt = ST_IDLE;
      default:               stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busReq   = (state != ST_IDLE);
  assign busValid = (state == ST_RD) || (state == ST_WR);
  assign busWe    = (state == ST_WR);

endmodule

// File: rtl/dma3_datapath.sv
module dma3_datapath
  import dma3_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dmaCmd_t             cmd,
  input  logic                cfgWe,
  input  logic [CH_IDX_W-1:0] cfgSel,
  input  logic [1:0]          cfgReg,
  input  logic [DATA_W-1:0]   cfgWdata,
  output logic [DATA_W-1:0]   cfgRdata,
  input  logic [DATA_W-1:0]   busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                busWide,
  output logic [DATA_W-1:0]   busWdata,
  output logic [NUM_CH-1:0]   enMask,
  output logic [NUM_CH-1:0]   tcMask
);

  logic [CH_IDX_W-1:0] curCh;
  logic [DATA_W-1:0]   holdQ;

  logic [NUM_CH-1:0][DATA_W-1:0] perV;
  logic [NUM_CH-1:0][ADDR_W-1:0] memV;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntV;
  logic [NUM_CH-1:0]             wideV, toPerV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCh <= '0;
      holdQ <= '0;
    end else begin
      if (cmd.grant)   curCh <= cmd.ch;
      if (cmd.capture) holdQ <= busRdata;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [8:0]        perBits;
      logic [ADDR_W-1:0] memQ;
      logic [CNT_W-1:0]  cntQ;
      logic              enQ, wideQ, toPerQ, tcQ;
      logic              hit, sel;

      assign hit = cmd.finish && (curCh == CH_IDX_W'(g));
      assign sel = cfgWe && (cfgSel == CH_IDX_W'(g));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          perBits <= '0;
          memQ    <= '0;
          cntQ    <= '0;
          enQ     <= 1'b0;
          wideQ   <= 1'b0;
          toPerQ  <= 1'b0;
          tcQ     <= 1'b0;
        end else if (hit) begin
          memQ <= memQ + (wideQ ? ADDR_W'(2) : ADDR_W'(1));
          if (cntQ == '0) begin
            tcQ <= 1'b1;
            enQ <= 1'b0;
          end else begin
            cntQ <= cntQ - CNT_W'(1);
          end
        end else if (sel) begin
          unique case (cfgReg)
            REG_PERIPH: perBits <= cfgWdata[9:1];
            REG_MEM:    memQ    <= ADDR_W'(cfgWdata);
            REG_COUNT:  cntQ    <= cfgWdata[CNT_W-1:0];
            default: begin
              enQ    <= cfgWdata[CB_EN];
              wideQ  <= cfgWdata[CB_WIDE];
              toPerQ <= cfgWdata[CB_TOPER];
              tcQ    <= cfgWdata[CB_TC];
            end
          endcase
        end
      end

      assign perV[g]   = {6'b0, perBits, 1'b0};
      assign memV[g]   = memQ;
      assign cntV[g]   = cntQ;
      assign enMask[g] = enQ;
      assign tcMask[g] = tcQ;
      assign wideV[g]  = wideQ;
      assign toPerV[g] = toPerQ;
    end
  endgenerate

  logic [DATA_W-1:0] curPer;
  logic [ADDR_W-1:0] curMem;
  logic              curWide, curToPer;
  logic [ADDR_W-1:0] srcAddr, dstAddr;

  always_comb begin
    curPer   = '0;
    curMem   = '0;
    curWide  = 1'b0;
    curToPer = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (curCh == CH_IDX_W'(i)) begin
        curPer   = perV[i];
        curMem   = memV[i];
        curWide  = wideV[i];
        curToPer = toPerV[i];
      end
    end
  end

  assign srcAddr  = curToPer ? curMem : ADDR_W'(curPer);
  assign dstAddr  = curToPer ? ADDR_W'(curPer) : curMem;
  assign busAddr  = cmd.phaseWr ? dstAddr : srcAddr;
  assign busWide  = curWide;
  assign busWdata = curWide ? holdQ : {8'h00, holdQ[7:0]};

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cfgSel == CH_IDX_W'(i)) begin
        unique case (cfgReg)
          REG_PERIPH: cfgRdata = perV[i];
          REG_MEM:    cfgRdata = DATA_W'(memV[i]);
          REG_COUNT:  cfgRdata = DATA_W'(cntV[i]);
          default:    cfgRdata = {12'h000, tcMask[i], toPerV[i], wideV[i], enMask[i]};
        endcase
      end
    end
  end

endmodule

// File: rtl/dma3_engine.sv
module dma3_engine
  import dma3_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 16,
  parameter int MAX_XFERS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [CH_IDX_W-1:0] cfgSel,
  input  logic [1:0]          cfgReg,
  input  logic [DATA_W-1:0]   cfgWdata,
  output logic [DATA_W-1:0]   cfgRdata,
  input  logic [NUM_CH-1:0]   dmaReq,
  output logic                busReq,
  input  logic                busGnt,
  output logic                busValid,
  output logic                busWe,
  output logic                busWide,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busRdy,
  output logic [NUM_CH-1:0]   irq
);

  localparam int CNT_W = $clog2(MAX_XFERS);

  dmaCmd_t           cmd;
  logic [NUM_CH-1:0] enMask;
  logic [NUM_CH-1:0] tcMask;

  dma3_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .req      (dmaReq),
    .enMask   (enMask),
    .busGnt   (busGnt),
    .busRdy   (busRdy),
    .busReq   (busReq),
    .busValid (busValid),
    .busWe    (busWe),
    .cmd      (cmd)
  );

  dma3_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .cfgReg   (cfgReg),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .busWide  (busWide),
    .busWdata (busWdata),
    .enMask   (enMask),
    .tcMask   (tcMask)
  );

  assign irq = tcMask;

endmodule

// File: rtl/dma3_engine_chk.sv
module dma3_engine_chk #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGnt,
  input logic              busValid,
  input logic              busWe,
  input logic              busWide,
  input logic              busRdy,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busWdata,
  input logic [NUM_CH-1:0] irq
);

  a_r9_valid_under_req: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busReq);

  a_r9_grant_before_access: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busValid) |-> $past(busGnt));

  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWe && busRdy) |=> (busValid && busWe));

  a_r10_hold_while_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busRdy) |=> (busValid && $stable(busWe) && $stable(busAddr) && $stable(busWide)));

  a_r3_release_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWe && busRdy) |=> !busValid);

  a_r5_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWe && !busWide) |-> (busWdata[15:8] == 8'h00));

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
      a_r8_irq_after_write: assert property (@(posedge clk) disable iff (!rstN)
        $rose(irq[g]) |-> $past(busValid && busWe && busRdy));
    end
  endgenerate

endmodule

bind dma3_engine dma3_engine_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk (.*);

// File: tb/dma3_engine_test.sv
`timescale 1ns/1ps
module dma3_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [1:0]  cfgReg = '0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic [2:0]  dmaReq = '0;
  logic        busReq, busValid, busWe, busWide;
  logic        busGnt = 1'b0;
  logic        busRdy = 1'b0;
  logic [15:0] busAddr, busWdata;
  logic [15:0] busRdata = '0;
  logic [2:0]  irq;

  int checks = 0;
  int fails  = 0;
  int gntAge = 0;
  int tick   = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          we;
    bit          wide;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } xfer_t;

  xfer_t expQ[$];
  xfer_t e;

  always #2 clk = ~clk;

  dma3_engine uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgReg(cfgReg),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .dmaReq(dmaReq), .busReq(busReq),
    .busGnt(busGnt), .busValid(busValid), .busWe(busWe), .busWide(busWide),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busRdy(busRdy),
    .irq(irq)
  );

  function automatic logic [15:0] model(input logic [15:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + a[7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expectXfer(input logic [15:0] src, input logic [15:0] dst, input bit wide, input string tag);
    xfer_t it;
    logic [15:0] v;
    v = model(src);
    it.we = 1'b0; it.wide = wide; it.addr = src; it.data = '0; it.tag = tag;
    expQ.push_back(it);
    it.we = 1'b1; it.addr = dst; it.data = wide ? v : {8'h00, v[7:0]};
    expQ.push_back(it);
  endtask

  // Bus slave and scoreboard monitor, away from the active edge.
  always @(negedge clk) begin
    if (!rstN) begin
      busGnt = 1'b0; busRdy = 1'b0; gntAge = 0;
    end else begin
      if (busReq) gntAge++; else gntAge = 0;
      if (busReq && !busGnt)
        check(!busValid, "R9", {31'b0, busValid}, 32'h0);
      busGnt = busReq && (gntAge >= 2);
      busRdy = 1'b0;
      if (busValid) begin
        tick++;
        busRdy = (tick % 3) != 0;
        if (busRdy) begin
          if (!busWe) busRdata = model(busAddr);
          if (expQ.size() == 0) begin
            check(1'b0, "R3", {busAddr, busWdata}, 32'h0);
          end else begin
            e = expQ.pop_front();
            check((busWe == e.we) && (busWide == e.wide) && (busAddr == e.addr) &&
                  (!e.we || busWdata == e.data), e.tag,
                  {busAddr, e.we ? busWdata : {15'b0, busWe}},
                  {e.addr, e.we ? e.data : 16'h0});
          end
        end
      end
    end
  end

  task automatic wrReg(input logic [1:0] ch, input logic [1:0] rg, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = ch; cfgReg = rg; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] ch, input logic [1:0] rg, output logic [15:0] d);
    @(negedge clk);
    cfgSel = ch; cfgReg = rg;
    #1 d = cfgRdata;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk);
    dmaReq = m;
    @(negedge clk);
    dmaReq = '0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (expQ.size() != 0 || busReq) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] ch, input logic [15:0] per, input logic [15:0] mem,
                       input logic [15:0] cnt, input logic [15:0] ctl);
    wrReg(ch, 2'd0, per);
    wrReg(ch, 2'd1, mem);
    wrReg(ch, 2'd2, cnt);
    wrReg(ch, 2'd3, ctl);
  endtask

  task automatic finishRun();
    check(expQ.size() == 0, "R3", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R12: reset state
    #1;
    check(irq == 3'b000, "R12", irq, 0);
    check(busReq == 1'b0, "R12", busReq, 0);
    for (int c = 0; c < 3; c++) begin
      rdReg(c[1:0], 2'd3, d);
      check(d == 16'h0, "R12", d, 0);
    end

    // R1: peripheral address field masking
    wrReg(2'd0, 2'd0, 16'hFFFF);
    rdReg(2'd0, 2'd0, d);
    check(d == 16'h03FE, "R1", d, 16'h03FE);
    wrReg(2'd0, 2'd0, 16'h1235);
    rdReg(2'd0, 2'd0, d);
    check(d == 16'h0234, "R1", d, 16'h0234);

    // R4/R6/R7/R8: channel 1, 16-bit, memory to peripheral, 3 transfers
    setup(2'd1, 16'h0040, 16'h1000, 16'd2, 16'h0007);
    for (int k = 0; k < 3; k++) begin
      expectXfer(16'h1000 + 16'(2 * k), 16'h0040, 1'b1, "R4");
      pulse(3'b010);
      waitIdle();
      if (k == 1) begin
        rdReg(2'd1, 2'd2, d);
        check(d == 16'h0, "R7", d, 0);
        check(irq == 3'b000, "R8", irq, 0);
      end
    end
    rdReg(2'd1, 2'd1, d);
    check(d == 16'h1006, "R6", d, 16'h1006);
    rdReg(2'd1, 2'd0, d);
    check(d == 16'h0040, "R6", d, 16'h0040);
    rdReg(2'd1, 2'd3, d);
    check(d == 16'h000E, "R7", d, 16'h000E);
    check(irq == 3'b010, "R8", irq, 3'b010);
    wrReg(2'd1, 2'd3, 16'h0006);
    #1 check(irq == 3'b000, "R8", irq, 0);

    // R5: channel 2, 8-bit, peripheral to memory
    setup(2'd2, 16'h0082, 16'h2001, 16'd1, 16'h0001);
    for (int k = 0; k < 2; k++) begin
      expectXfer(16'h0082, 16'h2001 + 16'(k), 1'b0, "R5");
      pulse(3'b100);
      waitIdle();
    end
    rdReg(2'd2, 2'd1, d);
    check(d == 16'h2003, "R6", d, 16'h2003);
    check(irq == 3'b100, "R8", irq, 3'b100);

    // R2: simultaneous requests
    setup(2'd0, 16'h0010, 16'h3000, 16'd0, 16'h0003);
    setup(2'd1, 16'h0020, 16'h3100, 16'd0, 16'h0007);
    setup(2'd2, 16'h0030, 16'h3200, 16'd0, 16'h0001);
    expectXfer(16'h0010, 16'h3000, 1'b1, "R2");
    expectXfer(16'h3100, 16'h0020, 1'b1, "R2");
    expectXfer(16'h0030, 16'h3200, 1'b0, "R2");
    pulse(3'b111);
    waitIdle();
    check(irq == 3'b111, "R8", irq, 3'b111);

    // R10: higher-priority requests land inside a running transfer
    setup(2'd0, 16'h0010, 16'h3000, 16'd0, 16'h0003);
    setup(2'd1, 16'h0020, 16'h3100, 16'd0, 16'h0007);
    setup(2'd2, 16'h0030, 16'h3200, 16'd0, 16'h0001);
    expectXfer(16'h0030, 16'h3200, 1'b0, "R10");
    expectXfer(16'h0010, 16'h3000, 1'b1, "R10");
    expectXfer(16'h3100, 16'h0020, 1'b1, "R10");
    pulse(3'b100);
    while (!busValid) @(negedge clk);
    dmaReq = 3'b010;
    @(negedge clk);
    dmaReq = 3'b001;
    @(negedge clk);
    dmaReq = 3'b000;
    waitIdle();

    // R11: request on a disabled channel is dropped
    setup(2'd0, 16'h0010, 16'h3000, 16'd0, 16'h0000);
    pulse(3'b001);
    repeat (10) @(negedge clk);
    check(busReq == 1'b0, "R11", busReq, 0);
    wrReg(2'd0, 2'd3, 16'h0001);
    repeat (10) @(negedge clk);
    check(busReq == 1'b0, "R11", busReq, 0);

    // R3: one pulse, one transfer
    setup(2'd1, 16'h0020, 16'h5000, 16'd3, 16'h0001);
    expectXfer(16'h0020, 16'h5000, 1'b0, "R3");
    pulse(3'b010);
    repeat (20) @(negedge clk);
    rdReg(2'd1, 2'd2, d);
    check(d == 16'h0002, "R3", d, 16'h0002);
    rdReg(2'd1, 2'd1, d);
    check(d == 16'h5001, "R3", d, 16'h5001);

    // R7: full 256-transfer run on channel 0
    setup(2'd0, 16'h0008, 16'h4000, 16'h00FF, 16'h0001);
    for (int k = 0; k < 256; k++) begin
      expectXfer(16'h0008, 16'h4000 + 16'(k), 1'b0, "R7");
      pulse(3'b001);
      waitIdle();
      if (k == 254) begin
        rdReg(2'd0, 2'd3, d);
        check(d == 16'h0001, "R7", d, 16'h0001);
      end
    end
    rdReg(2'd0, 2'd3, d);
    check(d == 16'h0008, "R7", d, 16'h0008);
    rdReg(2'd0, 2'd1, d);
    check(d == 16'h4100, "R7", d, 16'h4100);
    check(irq[0] == 1'b1, "R8", irq, 3'b001);

    done = 1'b1;
    finishRun();
  end

endmodule